// File: doc/BRIEF.md
# Repeated Byte Copy Engine

This block carries out one repeated block-move command in hardware. A command is presented as two bytes together with a start strobe. The only accepted pair is the repeat prefix 0xF2 followed by the move opcode 0xA4. When that pair arrives, the engine loads three working registers from its inputs: a source pointer, a destination pointer and a byte count. It then copies the string one byte at a time through a byte-wide memory port.

Each iteration does four things:
- reads the byte the source pointer addresses;
- writes that byte where the destination pointer points;
- advances both pointers by one;
- lowers the count by one.

The loop stops when the count is zero. The engine then emits a one-cycle completion pulse and goes idle. The three registers stay visible on the outputs with their final values. Any other byte pair is refused with a one-cycle illegal-command pulse, and no copy takes place.

The memory port is expected to return read data in the cycle after a read strobe. The pointers wrap modulo the address space.

Top module: `strcopy_engine`

## Requirements
- R1: After synchronous reset the engine is idle. busy, done, illegal, mem_rd_en and mem_wr_en are 0, and src_ptr, dst_ptr and count are 0.
- R2: A go pulse seen while idle, with cmd_pre = 0xF2 and cmd_op = 0xA4, is accepted at that clock edge. From the next cycle, busy is 1 and the registers hold src_in, dst_in and cnt_in.
- R3: For a count N, exactly N reads and N writes occur, never in the same cycle. Byte k of the destination receives byte k of the source, and no other memory location changes.
- R4: At completion, src_ptr and dst_ptr have each advanced by N from their loaded values, count is 0, and these values persist while idle.
- R5: done becomes 1 in the cycle after the (4N+1)-th clock edge following the accept edge. For N = 0 this is the cycle after the first edge, with no memory access at all.
- R6: done lasts exactly one cycle, and busy is 0 in the cycle after done.
- R7: A go pulse while idle with any other byte pair is refused. This includes the swapped pair and pairs with one byte altered. illegal is 1 for exactly the one cycle after the edge, busy stays 0, no memory access occurs, and the registers are unchanged.
- R8: go is ignored while busy, including the cycle in which done is 1. It causes no reload, no extra access, no illegal pulse and no second done.
- R9: Pointer arithmetic wraps modulo 2^AW, so a copy that crosses the top address continues at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start strobe for the presented command |
| cmd_pre | input | 8 | First command byte (prefix) |
| cmd_op | input | 8 | Second command byte (opcode) |
| src_in | input | AW | Source pointer value loaded on accept |
| dst_in | input | AW | Destination pointer value loaded on accept |
| cnt_in | input | CW | Byte count loaded on accept |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | 8 | Memory write data |
| src_ptr | output | AW | Current source pointer |
| dst_ptr | output | AW | Current destination pointer |
| count | output | CW | Remaining byte count |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle refused-command pulse |

## Verification
A new start strobe can coincide with a copy still in flight. It can also coincide with the completion cycle itself, where done is high and the state has not yet returned to idle. The bench raises go with a legal pair and different pointer values several times during a copy, and once in the exact cycle it sees done. It then judges the outcome at the ports. The final registers must match the first command only, the read and write counts must equal the first count, memory must match the reference, and neither illegal nor a second done may appear afterwards.

// File: rtl/strcopy_pkg.sv
package strcopy_pkg;
  localparam logic [7:0] REP_PREFIX = 8'hF2;
  localparam logic [7:0] MOVE_OP    = 8'hA4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_UPDATE,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import strcopy_pkg::*;
(
  input  logic [7:0] pre_byte,
  input  logic [7:0] op_byte,
  output logic       legal
);
  // only the exact prefix-then-opcode pair is a copy command
  always_comb begin
    legal = (pre_byte == REP_PREFIX) && (op_byte == MOVE_OP);
  end
endmodule

// File: rtl/copy_regs.sv
module copy_regs #(
  parameter int AW = 10,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero
);
  localparam logic [AW-1:0] PTR_INC = AW'(1);
  localparam logic [CW-1:0] CNT_DEC = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load) begin
      src <= src_in;
      dst <= dst_in;
      cnt <= cnt_in;
    end else if (step) begin
      src <= src + PTR_INC;
      dst <= dst + PTR_INC;
      cnt <= cnt - CNT_DEC;
    end
  end

  always_comb cnt_zero = (cnt == '0);
endmodule

// File: rtl/copy_ctrl.sv
module copy_ctrl
  import strcopy_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          legal,
  input  logic          cnt_zero,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic [7:0]    rd_data,
  output logic          load,
  output logic          step,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  seq_state_t state;

  always_comb begin
    load = (state == ST_IDLE) && go && legal;
    step = (state == ST_UPDATE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            if (legal) begin
              state <= ST_CHECK;
              busy  <= 1'b1;
            end else begin
              illegal <= 1'b1;
            end
          end
        end
        ST_CHECK: begin
          if (cnt_zero) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end else begin
            state   <= ST_READ;
            rd_en   <= 1'b1;
            rd_addr <= src;
          end
        end
        ST_READ: begin
          // memory returns the byte during the next state
          state <= ST_WRITE;
        end
        ST_WRITE: begin
          state   <= ST_UPDATE;
          wr_en   <= 1'b1;
          wr_addr <= dst;
          wr_data <= rd_data;
        end
        ST_UPDATE: begin
          state <= ST_CHECK;
        end
        ST_DONE: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/strcopy_engine.sv
module strcopy_engine
  import strcopy_pkg::*;
#(
  parameter int AW = 10,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [7:0]    cmd_pre,
  input  logic [7:0]    cmd_op,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          done,
  output logic          illegal
);
  logic legal;
  logic load;
  logic step;
  logic cnt_zero;

  cmd_decoder u_dec (
    .pre_byte (cmd_pre),
    .op_byte  (cmd_op),
    .legal    (legal)
  );

  copy_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .src_in   (src_in),
    .dst_in   (dst_in),
    .cnt_in   (cnt_in),
    .src      (src_ptr),
    .dst      (dst_ptr),
    .cnt      (count),
    .cnt_zero (cnt_zero)
  );

  copy_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .legal    (legal),
    .cnt_zero (cnt_zero),
    .src      (src_ptr),
    .dst      (dst_ptr),
    .rd_data  (mem_rd_data),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done),
    .illegal  (illegal),
    .rd_en    (mem_rd_en),
    .rd_addr  (mem_rd_addr),
    .wr_en    (mem_wr_en),
    .wr_addr  (mem_wr_addr),
    .wr_data  (mem_wr_data)
  );
endmodule

// File: rtl/strcopy_checks.sv
module strcopy_checks #(
  parameter int AW = 10,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          done,
  input logic          illegal
);
  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: a read and a write never share a cycle
  p_rdwr_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  // R3: every read is followed, two cycles later, by its write
  p_write_follows_read_r3: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_wr_en ##1 mem_wr_en);

  // R4: each write step advances pointers and lowers the count
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> (src_ptr == $past(src_ptr) + AW'(1)) &&
                  (dst_ptr == $past(dst_ptr) + AW'(1)) &&
                  (count == $past(count) - CW'(1)));

  // R5: completion only with the count exhausted
  p_done_cnt_zero_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (count == '0) && busy);

  // R7: a refused command never starts work
  p_illegal_idle_r7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy && !done);

  // R8: no memory traffic outside a copy
  p_no_access_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_rd_en && !mem_wr_en);
endmodule

bind strcopy_engine strcopy_checks #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .src_ptr   (src_ptr),
  .dst_ptr   (dst_ptr),
  .count     (count),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal)
);

// File: tb/sim_strcopy_engine.sv
`timescale 1ns/1ps
module sim_strcopy_engine;
  localparam int AW = 10;
  localparam int CW = 12;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          go = 1'b0;
  logic [7:0]    cmd_pre = '0;
  logic [7:0]    cmd_op = '0;
  logic [AW-1:0] src_in = '0;
  logic [AW-1:0] dst_in = '0;
  logic [CW-1:0] cnt_in = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0]    mem_wr_data;
  logic [AW-1:0] src_ptr;
  logic [AW-1:0] dst_ptr;
  logic [CW-1:0] count;
  logic          busy;
  logic          done;
  logic          illegal;

  int checks = 0;
  int errors = 0;
  int rd_n = 0;
  int wr_n = 0;
  int ill_n = 0;
  int done_n = 0;
  bit finished = 0;

  logic [7:0] mem [MSZ];
  logic [7:0] ref_mem [MSZ];

  always #2 clk = ~clk;

  strcopy_engine #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .go(go), .cmd_pre(cmd_pre), .cmd_op(cmd_op),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .count(count),
    .busy(busy), .done(done), .illegal(illegal)
  );

  // byte memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_rd_en) rd_n++;
      if (mem_wr_en) wr_n++;
      if (illegal)   ill_n++;
      if (done)      done_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < MSZ; i++) begin
      mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
      ref_mem[i] = mem[i];
    end
  endtask

  task automatic compare_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < MSZ; i++) if (mem[i] !== ref_mem[i]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  // drive a command; returns positioned at the negedge after the accept edge
  task automatic issue(input logic [7:0] p, input logic [7:0] o,
                       input int s, input int d, input int n);
    @(negedge clk);
    cmd_pre = p; cmd_op = o;
    src_in = AW'(s); dst_in = AW'(d); cnt_in = CW'(n);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  // forward byte copy as the requirements describe
  task automatic model_copy(input int s, input int d, input int n);
    for (int k = 0; k < n; k++)
      ref_mem[(d + k) % MSZ] = ref_mem[(s + k) % MSZ];
  endtask

  task automatic run_copy(input int s, input int d, input int n, input string tag);
    int k = 0;
    int rd0, wr0;
    rd0 = rd_n; wr0 = wr_n;
    model_copy(s, d, n);
    issue(8'hF2, 8'hA4, s, d, n);
    check(busy === 1'b1, {tag, " R2 busy after accept"}, int'(busy), 1);
    check(src_ptr == AW'(s) && dst_ptr == AW'(d) && count == CW'(n),
          {tag, " R2 registers loaded"}, int'(src_ptr), s);
    while (done !== 1'b1 && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(k == 4 * n + 1, {tag, " R5 done latency"}, k, 4 * n + 1);
    check(src_ptr == AW'(s + n) && dst_ptr == AW'(d + n) && count == '0,
          {tag, " R4 final registers"}, int'(dst_ptr), (d + n) % MSZ);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {tag, " R6 done single cycle"},
          int'(done) + 2 * int'(busy), 0);
    check(rd_n - rd0 == n && wr_n - wr0 == n, {tag, " R3 access count"},
          rd_n - rd0, n);
    compare_mem({tag, " R3 memory contents"});
    repeat (3) @(negedge clk);
    check(src_ptr == AW'(s + n) && count == '0, {tag, " R4 values held"},
          int'(src_ptr), (s + n) % MSZ);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !illegal && !mem_rd_en && !mem_wr_en,
          "R1 control outputs after reset", int'(busy), 0);
    check(src_ptr == '0 && dst_ptr == '0 && count == '0,
          "R1 registers after reset", int'(count), 0);
  endtask

  task automatic t_zero();
    int rd0 = rd_n;
    int k = 0;
    issue(8'hF2, 8'hA4, 100, 200, 0);
    while (done !== 1'b1 && k < 50) begin
      @(negedge clk);
      k++;
    end
    check(k == 1, "R5 zero count completes after one edge", k, 1);
    check(rd_n == rd0 && wr_n == rd_n - rd0 + wr_n, "R5 zero count no reads", rd_n - rd0, 0);
    @(negedge clk);
    check(done === 1'b0, "R6 zero count pulse width", int'(done), 0);
    compare_mem("R5 zero count memory untouched");
  endtask

  task automatic t_illegal();
    logic [7:0] pairs [4][2];
    pairs[0][0] = 8'hA4; pairs[0][1] = 8'hF2;
    pairs[1][0] = 8'hF2; pairs[1][1] = 8'hA5;
    pairs[2][0] = 8'hF3; pairs[2][1] = 8'hA4;
    pairs[3][0] = 8'h00; pairs[3][1] = 8'h00;
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] s0 = src_ptr;
      logic [AW-1:0] d0 = dst_ptr;
      logic [CW-1:0] c0 = count;
      int rd0 = rd_n;
      issue(pairs[i][0], pairs[i][1], 5, 9, 7);
      check(illegal === 1'b1 && busy === 1'b0, "R7 illegal pulse raised",
            int'(illegal), 1);
      @(negedge clk);
      check(illegal === 1'b0 && busy === 1'b0, "R7 illegal one cycle, no start",
            int'(illegal) + 2 * int'(busy), 0);
      check(src_ptr == s0 && dst_ptr == d0 && count == c0 && rd_n == rd0,
            "R7 registers and memory untouched", int'(src_ptr), int'(s0));
    end
    compare_mem("R7 memory after refused commands");
  endtask

  task automatic t_go_busy();
    int k = 0;
    int rd0 = rd_n;
    int ill0 = ill_n;
    int dn0 = done_n;
    model_copy(300, 400, 3);
    issue(8'hF2, 8'hA4, 300, 400, 3);
    while (done !== 1'b1 && k < 200) begin
      if (k == 2 || k == 7) begin
        cmd_pre = 8'hF2; cmd_op = 8'hA4;
        src_in = AW'(600); dst_in = AW'(700); cnt_in = CW'(9);
        go = 1'b1;
      end else begin
        go = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    // go coincides with the completion cycle
    go = 1'b1;
    src_in = AW'(10); dst_in = AW'(20); cnt_in = CW'(1);
    @(negedge clk);
    go = 1'b0;
    repeat (20) @(negedge clk);
    check(src_ptr == AW'(303) && dst_ptr == AW'(403) && count == '0,
          "R8 registers keep first command", int'(src_ptr), 303);
    check(rd_n - rd0 == 3, "R8 no extra reads", rd_n - rd0, 3);
    check(ill_n == ill0 && done_n == dn0 + 1, "R8 no illegal or second done",
          done_n - dn0, 1);
    compare_mem("R8 memory matches first command");
  endtask

  initial begin
    fill_mem();
    t_reset();
    run_copy(16, 128, 1, "single byte");
    run_copy(40, 500, 13, "thirteen bytes");
    run_copy(200, 210, 6, "nearby blocks");
    t_zero();
    t_illegal();
    t_go_busy();
    run_copy(MSZ - 2, 64, 5, "R9 source wrap");
    run_copy(700, MSZ - 3, 6, "R9 destination wrap");
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule